// File: doc/BRIEF.md
# Reversible Fault Test Vector Generator

This block produces test vectors that activate a chosen fault on one k-control Toffoli gate of a reversible circuit. The gate is described by a mask of its control lines and the index of its target line, and a fault code selects the fault model. For a fault where some control connections are absent, a second mask names those absent controls. The vector produced is the value required on the gate's own lines. Earlier gates in the circuit are not taken into account.

A request is taken on a one-cycle `start_i` pulse while the block is idle. In single mode the block answers one cycle later with the smallest vector that activates the fault. In enumerate mode it sends every activating vector, one per clock cycle with `vld_o` high, and raises `last_o` on the final one. Each vector carries the fault order: the control count less the number of absent controls. An inconsistent request gets a one-cycle error pulse and no vector.

Top module: `rfg_vec_gen`

## Requirements
- R1: While reset is asserted and after it is released, `vld_o`, `last_o`, `err_o` and `busy_o` are 0 until a request is accepted.
- R2: For fault code 0 (whole gate missing) and fault code 3 (run of consecutive missing gates, described by the first missing gate), every control line in the control mask is 1 in every vector produced.
- R3: Fault code 1 (repeated gate) produces the same vectors as fault code 0.
- R4: For fault code 2 (absent controls), every vector has exactly one control line at 0, that line is in the absent-control mask, and every other control line is 1.
- R5: When `enum_i` is 0, exactly one vector follows, one cycle after start, with `last_o` high. It is the smallest activating value: lines outside the control mask are 0, and for fault code 2 the highest-indexed absent control is the 0 line.
- R6: When `enum_i` is 1, vectors come one per cycle starting one cycle after start. The lines outside the control mask, including the target line, step through all their combinations in increasing binary order.
- R7: For fault code 2 in enumerate mode, there is one group per absent control, taken from the lowest index upward. Each group is a full sweep as in R6, giving p × 2^F vectors in total.
- R8: `last_o` is high on the final vector of a request and on no other, and `vld_o` is low in the cycle after it.
- R9: `order_o` equals the number of control lines minus the number of absent controls for fault code 2, and the number of control lines for the other codes.
- R10: A request is refused if it is fault code 2 with an empty absent-control mask, or fault code 2 with absent-control bits outside the control mask, or any fault code where the target line lies in the control mask. A refused request gets `err_o` high for one cycle, one cycle after start, and no `vld_o`.
- R11: A start pulse while `busy_o` is high is ignored and produces no output.
- R12: For fault codes other than 2, the absent-control mask has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken when idle |
| fault_i | input | 2 | Fault code: 0 whole gate, 1 repeated, 2 absent controls, 3 consecutive gates |
| enum_i | input | 1 | 1 = list all vectors, 0 = smallest only |
| ctrl_mask_i | input | N_LINES | Control lines of the gate |
| target_idx_i | input | $clog2(N_LINES) | Target line index |
| miss_mask_i | input | N_LINES | Absent controls (fault code 2) |
| vld_o | output | 1 | Vector valid |
| vec_o | output | N_LINES | Test vector |
| last_o | output | 1 | Final vector of the request |
| order_o | output | $clog2(N_LINES+1) | Fault order |
| err_o | output | 1 | Request refused |
| busy_o | output | 1 | Request in progress |

## Verification
The bench targets the borders of the sweep. It covers a gate with no controls, where all 256 values come out, and a fault where every control is absent, which gives order 0. A counter that did not skip the control lines would repeat vectors or produce values that break the control rule. A group change in the wrong direction, or a group missing for the top absent control, would show up as a mismatch against the model's ordered list. Single mode is checked with two absent controls, where picking the lowest one gives a larger value than required. The bench also sends each malformed absent-control mask and a target that overlaps the controls, a garbage mask on a whole-gate fault, and a start in the middle of a sweep; a design that accepted any of these would produce output the scoreboard does not expect.

// File: rtl/rfg_pkg.sv
package rfg_pkg;

  typedef enum logic [1:0] {
    FLT_GATE_MISS  = 2'd0,
    FLT_GATE_REP   = 2'd1,
    FLT_CTRL_MISS  = 2'd2,
    FLT_MULTI_MISS = 2'd3
  } fault_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

endpackage

// File: rtl/rfg_req_check.sv
module rfg_req_check
  import rfg_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N),
  parameter int CNT_W = $clog2(N + 1)
) (
  input  fault_e             fault_i,
  input  logic               single_i,
  input  logic [N-1:0]       ctrl_i,
  input  logic [IDX_W-1:0]   target_i,
  input  logic [N-1:0]       miss_i,
  output logic               bad_o,
  output logic               partial_o,
  output logic [CNT_W-1:0]   order_o,
  output logic [N-1:0]       rem_init_o
);

  logic [CNT_W-1:0] ctrl_cnt;
  logic [CNT_W-1:0] miss_cnt;
  logic [N-1:0]     miss_top;
  logic [N-1:0]     tgt_bit;
  logic             miss_empty;
  logic             miss_stray;

  // Count controls and absent controls, and find the highest absent control
  always_comb begin
    ctrl_cnt = '0;
    miss_cnt = '0;
    miss_top = '0;
    for (int i = 0; i < N; i++) begin
      if (ctrl_i[i]) ctrl_cnt = ctrl_cnt + CNT_W'(1);
      if (miss_i[i]) begin
        miss_cnt = miss_cnt + CNT_W'(1);
        miss_top = N'(1) << i;
      end
    end
  end

  always_comb begin
    tgt_bit    = N'(1) << target_i;
    partial_o  = (fault_i == FLT_CTRL_MISS);
    miss_empty = (miss_i == '0);
    miss_stray = |(miss_i & ~ctrl_i);
    bad_o      = (|(ctrl_i & tgt_bit)) | (partial_o & (miss_empty | miss_stray));
    order_o    = partial_o ? (ctrl_cnt - miss_cnt) : ctrl_cnt;
    if (!partial_o)    rem_init_o = '0;
    else if (single_i) rem_init_o = miss_top;
    else               rem_init_o = miss_i;
  end

endmodule

// File: rtl/rfg_free_cnt.sv
module rfg_free_cnt #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [N-1:0] free_mask_i,
  output logic [N-1:0] cnt_o,
  output logic         wrap_o
);

  logic [N-1:0] cnt_q;
  logic [N-1:0] cnt_d;
  logic [N-1:0] bumped;
  logic         cnt_en;

  // Carry ripples through the fixed lines because they are forced to 1
  always_comb begin
    bumped = (cnt_q | ~free_mask_i) + N'(1);
    wrap_o = (cnt_q == free_mask_i);
    cnt_en = load_i | step_i;
    if (load_i || wrap_o) cnt_d = '0;
    else                  cnt_d = bumped & free_mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_FREE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !wrap_o) |=> (cnt_q > $past(cnt_q))); // R6

  AST_FREE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ((cnt_q & ~free_mask_i) == '0)); // R6

endmodule

// File: rtl/rfg_miss_sel.sv
module rfg_miss_sel #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] load_val_i,
  input  logic         adv_i,
  output logic [N-1:0] sel_o,
  output logic         final_o
);

  logic [N-1:0] rem_q;
  logic [N-1:0] rem_d;
  logic         rem_en;

  always_comb begin
    sel_o   = rem_q & (~rem_q + N'(1));
    final_o = ((rem_q & ~sel_o) == '0);
    rem_en  = load_i | adv_i;
    rem_d   = load_i ? load_val_i : (rem_q & ~sel_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  AST_GROUP_UPWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !final_o) |=> (sel_o > $past(sel_o))); // R7

  AST_GROUP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !final_o) |=> (rem_q != '0)); // R7

endmodule

// File: rtl/rfg_vec_gen.sv
module rfg_vec_gen
  import rfg_pkg::*;
#(
  parameter  int N_LINES = 8,
  localparam int IDX_W   = $clog2(N_LINES),
  localparam int CNT_W   = $clog2(N_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         fault_i,
  input  logic               enum_i,
  input  logic [N_LINES-1:0] ctrl_mask_i,
  input  logic [IDX_W-1:0]   target_idx_i,
  input  logic [N_LINES-1:0] miss_mask_i,
  output logic               vld_o,
  output logic [N_LINES-1:0] vec_o,
  output logic               last_o,
  output logic [CNT_W-1:0]   order_o,
  output logic               err_o,
  output logic               busy_o
);

  run_state_e         state_q, state_d;
  logic               single_q, partial_q, err_q;
  logic [N_LINES-1:0] ctrl_q;
  logic [CNT_W-1:0]   order_q;

  logic               req_bad, req_partial;
  logic [CNT_W-1:0]   req_order;
  logic [N_LINES-1:0] req_rem;
  logic               accept, load_ok, running;
  logic               group_end, at_last;
  logic               free_step, miss_adv;
  logic [N_LINES-1:0] free_val, sel_bit;
  logic               sel_final;

  rfg_req_check #(.N(N_LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
    .fault_i    (fault_e'(fault_i)),
    .single_i   (~enum_i),
    .ctrl_i     (ctrl_mask_i),
    .target_i   (target_idx_i),
    .miss_i     (miss_mask_i),
    .bad_o      (req_bad),
    .partial_o  (req_partial),
    .order_o    (req_order),
    .rem_init_o (req_rem)
  );

  rfg_free_cnt #(.N(N_LINES)) free_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_ok),
    .step_i      (free_step),
    .free_mask_i (~ctrl_q),
    .cnt_o       (free_val),
    .wrap_o      (group_end)
  );

  rfg_miss_sel #(.N(N_LINES)) msel_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_ok),
    .load_val_i (req_rem),
    .adv_i      (miss_adv),
    .sel_o      (sel_bit),
    .final_o    (sel_final)
  );

  // Sequencing
  always_comb begin
    running   = (state_q == ST_RUN);
    accept    = start_i & ~running;
    load_ok   = accept & ~req_bad;
    at_last   = running & (single_q | (group_end & (~partial_q | sel_final)));
    free_step = running & ~at_last;
    miss_adv  = free_step & partial_q & group_end;
    state_d   = state_q;
    if (load_ok)      state_d = ST_RUN;
    else if (at_last) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= accept & req_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q  <= 1'b0;
      partial_q <= 1'b0;
      ctrl_q    <= '0;
      order_q   <= '0;
    end else if (load_ok) begin
      single_q  <= ~enum_i;
      partial_q <= req_partial;
      ctrl_q    <= ctrl_mask_i;
      order_q   <= req_order;
    end
  end

  always_comb begin
    vld_o   = running;
    last_o  = at_last;
    vec_o   = running ? (free_val | (ctrl_q & ~sel_bit)) : '0;
    order_o = order_q;
    err_o   = err_q;
    busy_o  = running;
  end

  AST_VLD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_o && err_o)); // R10

  AST_WHOLE_CTRLS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !partial_q) |-> ((vec_o & ctrl_q) == ctrl_q)); // R2

  AST_PART_ONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && partial_q) |-> ($countones(ctrl_q & ~vec_o) == 1)); // R4

  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && last_o) |=> !vld_o); // R8

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !last_o) |=> vld_o); // R6

endmodule

// File: tb/rfg_vec_gen_tb_top.sv
module rfg_vec_gen_tb_top;

  localparam int N = 8;
  localparam int CW = 4;

  typedef struct packed {
    logic [N-1:0]  vec;
    logic          last;
    logic [CW-1:0] order;
    logic          err;
    int            cyc;
    int            req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [1:0]    fault_i;
  logic          enum_i;
  logic [N-1:0]  ctrl_mask_i;
  logic [2:0]    target_idx_i;
  logic [N-1:0]  miss_mask_i;
  logic          vld_o;
  logic [N-1:0]  vec_o;
  logic          last_o;
  logic [CW-1:0] order_o;
  logic          err_o;
  logic          busy_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  rfg_vec_gen #(.N_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fault_i(fault_i),
    .enum_i(enum_i), .ctrl_mask_i(ctrl_mask_i), .target_idx_i(target_idx_i),
    .miss_mask_i(miss_mask_i), .vld_o(vld_o), .vec_o(vec_o), .last_o(last_o),
    .order_o(order_o), .err_o(err_o), .busy_o(busy_o)
  );

  // Monitor: every output cycle must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && (vld_o || err_o)) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected output vld=%b err=%b vec=%h, expected none", vld_o, err_o, vec_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.err) begin
          if (!err_o || vld_o || cyc != e.cyc) begin
            errors++;
            $display("FAIL R%0d error response err=%b vld=%b cyc=%0d, expected err=1 vld=0 cyc=%0d",
                     e.req, err_o, vld_o, cyc, e.cyc);
          end
        end else if (!vld_o || err_o || vec_o !== e.vec || last_o !== e.last ||
                     order_o !== e.order || cyc != e.cyc) begin
          errors++;
          $display("FAIL R%0d vec=%h last=%b order=%0d err=%b cyc=%0d, expected vec=%h last=%b order=%0d err=0 cyc=%0d",
                   e.req, vec_o, last_o, order_o, err_o, cyc, e.vec, e.last, e.order, e.cyc);
        end
      end
    end
  end

  function automatic logic act_ok(input logic [1:0] f, input logic [N-1:0] c,
                                  input logic [N-1:0] m, input logic [N-1:0] v, input int j);
    logic [N-1:0] need;
    if (f != 2'd2) return ((v & c) == c);
    need = c & ~(N'(1) << j);
    return (m[j] && !v[j] && ((v & need) == need));
  endfunction

  // Driver: builds the expected items independently, then issues the request
  task automatic run_job(input logic [1:0] f, input logic en, input logic [N-1:0] c,
                         input logic [2:0] t, input logic [N-1:0] m,
                         input logic bad, input int req);
    exp_t e;
    int s;
    int idx;
    logic [CW-1:0] ord;
    logic found;
    @(negedge clk);
    s = cyc;
    ord = (f == 2'd2) ? CW'($countones(c) - $countones(m)) : CW'($countones(c));
    idx = 0;
    if (bad) begin
      e = '{vec: '0, last: 1'b0, order: '0, err: 1'b1, cyc: s + 1, req: req};
      sb_q.push_back(e);
    end else if (!en) begin
      found = 1'b0;
      for (int v = 0; v < (1 << N); v++) begin
        for (int j = 0; j < N; j++) begin
          if (!found && act_ok(f, c, m, N'(v), j)) begin
            found = 1'b1;
            e = '{vec: N'(v), last: 1'b1, order: ord, err: 1'b0, cyc: s + 1, req: req};
            sb_q.push_back(e);
          end
        end
      end
    end else begin
      for (int j = 0; j < N; j++) begin
        if (f == 2'd2 ? m[j] : (j == 0)) begin
          for (int v = 0; v < (1 << N); v++) begin
            if (act_ok(f, c, m, N'(v), j)) begin
              e = '{vec: N'(v), last: 1'b0, order: ord, err: 1'b0, cyc: s + 1 + idx, req: req};
              sb_q.push_back(e);
              idx++;
            end
          end
        end
      end
      sb_q[sb_q.size() - 1].last = 1'b1;
    end
    fault_i = f; enum_i = en; ctrl_mask_i = c; target_idx_i = t; miss_mask_i = m;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; fault_i = '0; enum_i = 1'b0;
    ctrl_mask_i = '0; target_idx_i = '0; miss_mask_i = '0;
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (vld_o || last_o || err_o || busy_o) begin
      errors++;
      $display("FAIL R1 vld=%b last=%b err=%b busy=%b, expected all 0", vld_o, last_o, err_o, busy_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checks++;  // R1 after release
    if (vld_o || last_o || err_o || busy_o) begin
      errors++;
      $display("FAIL R1 after release vld=%b last=%b err=%b busy=%b, expected all 0", vld_o, last_o, err_o, busy_o);
    end

    run_job(2'd0, 1'b0, 8'h06, 3'd0, 8'h00, 1'b0, 2);  drain(); // R2 R5
    run_job(2'd1, 1'b0, 8'hA0, 3'd3, 8'h00, 1'b0, 3);  drain(); // R3
    run_job(2'd3, 1'b1, 8'hF8, 3'd0, 8'h00, 1'b0, 2);  drain(); // R2 R6 R8
    run_job(2'd2, 1'b0, 8'h38, 3'd1, 8'h28, 1'b0, 5);  drain(); // R5 R4
    run_job(2'd2, 1'b1, 8'h38, 3'd1, 8'h28, 1'b0, 7);  drain(); // R7 R4
    run_job(2'd1, 1'b1, 8'h81, 3'd4, 8'h00, 1'b0, 6);  drain(); // R6 R3
    run_job(2'd2, 1'b0, 8'h38, 3'd0, 8'h00, 1'b1, 10); drain(); // R10 empty mask
    run_job(2'd2, 1'b1, 8'h38, 3'd0, 8'h40, 1'b1, 10); drain(); // R10 stray bit
    run_job(2'd0, 1'b0, 8'h06, 3'd1, 8'h00, 1'b1, 10); drain(); // R10 target in controls
    run_job(2'd0, 1'b0, 8'h06, 3'd0, 8'h41, 1'b0, 12); drain(); // R12 garbage mask ignored
    run_job(2'd3, 1'b1, 8'hF0, 3'd0, 8'h0F, 1'b0, 12); drain(); // R12 enumerate
    run_job(2'd2, 1'b0, 8'hF0, 3'd0, 8'h30, 1'b0, 9);  drain(); // R9 order 2
    run_job(2'd0, 1'b1, 8'h00, 3'd0, 8'h00, 1'b0, 9);  drain(); // R9 order 0, R6 full sweep
    run_job(2'd2, 1'b1, 8'h03, 3'd2, 8'h03, 1'b0, 7);  drain(); // R7 every control absent, R9

    // R11: start during a sweep must be ignored
    run_job(2'd0, 1'b1, 8'hF8, 3'd0, 8'h00, 1'b0, 11);
    @(negedge clk);
    fault_i = 2'd1; enum_i = 1'b0; ctrl_mask_i = 8'h01; target_idx_i = 3'd5; miss_mask_i = 8'h00;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    checks++;  // R11 nothing left behind
    if (busy_o || sb_q.size() != 0) begin
      errors++;
      $display("FAIL R11 busy=%b pending=%0d, expected busy=0 pending=0", busy_o, sb_q.size());
    end
    // R8: block must be idle once the final vector has gone
    checks++;
    if (vld_o) begin
      errors++;
      $display("FAIL R8 vld=%b after last, expected 0", vld_o);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++;
    checks++;
    $display("FAIL watchdog cyc=%0d, expected completion", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule